// File: doc/BRIEF.md
# Sticky Transfer-Completion Interrupt Flag Bank

This block keeps one sticky completion flag per channel of a hardware-triggered transfer engine. A flag is raised in two cases. The first is a hardware-started transfer that finishes while its descriptor asks for an interrupt. The second is a chained descriptor, running after a hardware-started one, that asks for an interrupt. A raised flag stays set until software clears it or a standby command arrives. Every flag drives its own level interrupt line towards the interrupt controller.

Software sees the flags as a window of read-only 32-bit status words. Flags are cleared through a second window of write-one-to-clear words. A `CH_COUNT` parameter (64, 128 or 256) marks the flags at and above that index as reserved. Reserved flags can never be set and always read as zero.

The register port uses a small state machine with two states. `BUS_IDLE` means no read response is pending. `BUS_RDATA` means the read data of the previous cycle is being presented. A read strobe moves the port from `BUS_IDLE` to `BUS_RDATA`, or keeps it in `BUS_RDATA`. A cycle without a read strobe returns it to `BUS_IDLE`.

Top module: `cmpl_flag_bank`

## Requirements
- R1: After reset every flag is 0, `irq_out` is all zeros, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: A read of byte offset 0x30+4k returns flags 32k+31 down to 32k. The data is on `bus_rdata` with `bus_rvalid` high in the cycle after the read strobe. `bus_rvalid` is low in any cycle that does not follow a read strobe.
- R3: When `xfer_done[i]` and `xfer_irq_en[i]` are both high in a cycle, flag i is 1 from the next cycle. `xfer_done[i]` alone sets nothing.
- R4: A high `chain_irq[i]` sets flag i from the next cycle.
- R5: A write to a status word changes no flag.
- R6: Writing a word with bit j at 1 to byte offset 0x50+4k clears flag 32k+j from the next cycle. Bits written as 0 leave their flags unchanged.
- R7: A high `standby_req` clears every flag in the next cycle.
- R8: A set event wins over a clear or a standby command for the same flag in the same cycle.
- R9: `irq_out[i]` is high exactly while flag i is 1.
- R10: A flag with index at or above `CH_COUNT` is never set, and reads and drives 0.
- R11: Reads of the clear words at 0x50 to 0x6C, and of any offset outside both windows, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| xfer_done | input | NUM_CH | Per-channel hardware transfer completion pulse |
| xfer_irq_en | input | NUM_CH | Descriptor interrupt-request bit for the completing transfer |
| chain_irq | input | NUM_CH | Chained descriptor completion with interrupt request |
| standby_req | input | 1 | Standby transition command, clears all flags |
| irq_out | output | NUM_CH | Per-channel completion interrupt levels |

## Verification
Each flag flop drives an interrupt pin directly, so a wrong flag state shows on `irq_out` one cycle after the event that caused it. The same wrong state shows on the status word at the next read. The bench sweeps every one of the 256 channel positions with a reserved upper half. It compares the pin and the word after each set, after an ignored status write, after a zero clear and after a real clear. A lost or stuck flag therefore shows within two cycles of the stimulus. A misplaced bit or word decode shows as a wrong bit in the word that is read back.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [0:0] {
        BUS_IDLE  = 1'b0,
        BUS_RDATA = 1'b1
    } bus_state_e;

endpackage

// File: rtl/cfb_flag_word.sv
module cfb_flag_word #(
    parameter int WORD_W   = 32,
    parameter int WORD_IDX = 0,
    parameter int CH_COUNT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_in,
    input  logic              clr_we,
    input  logic [WORD_W-1:0] clr_bits,
    input  logic              standby,
    output logic [WORD_W-1:0] flags
);

    localparam int BASE = WORD_IDX * WORD_W;

    logic [WORD_W-1:0] live;
    logic [WORD_W-1:0] flags_d;

    for (genvar b = 0; b < WORD_W; b++) begin : g_live
        assign live[b] = ((BASE + b) < CH_COUNT);
    end

    always_comb begin
        flags_d = flags;
        if (standby) begin
            flags_d = '0;
        end else if (clr_we) begin
            flags_d = flags & ~clr_bits;
        end
        flags_d = (flags_d | set_in) & live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= flags_d;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~live) == '0);  // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_in & live)) |=> ((flags & $past(set_in & live)) == $past(set_in & live)));  // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !standby) |=> ((flags & $past(clr_bits & ~set_in)) == '0));  // R6
    AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (flags == $past(set_in & live)));  // R7

endmodule

// File: rtl/cfb_bus_port.sv
module cfb_bus_port
    import cfb_pkg::*;
#(
    parameter int              NUM_WORDS = 8,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_BASE = 8'h30,
    parameter logic [ADDR_W-1:0] CLR_BASE  = 8'h50
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [WORD_W-1:0]           bus_wdata,
    input  logic [NUM_WORDS*WORD_W-1:0] flags,
    output logic [NUM_WORDS-1:0]        clr_we,
    output logic [WORD_W-1:0]           clr_bits,
    output logic                        stat_wr,
    output logic [WORD_W-1:0]           bus_rdata,
    output logic                        bus_rvalid
);

    bus_state_e state_q, state_d;

    logic                 rd_stb;
    logic                 wr_stb;
    logic [NUM_WORDS-1:0] stat_hit;
    logic [NUM_WORDS-1:0] clr_hit;
    logic [WORD_W-1:0]    rd_mux;

    assign rd_stb   = bus_sel && !bus_wr;
    assign wr_stb   = bus_sel && bus_wr;
    assign clr_bits = bus_wdata;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
        assign stat_hit[w] = (bus_addr == (STAT_BASE + ADDR_W'(4 * w)));
        assign clr_hit[w]  = (bus_addr == (CLR_BASE + ADDR_W'(4 * w)));
        assign clr_we[w]   = wr_stb && clr_hit[w];
    end

    assign stat_wr = wr_stb && (|stat_hit);

    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (stat_hit[w]) begin
                rd_mux = flags[w*WORD_W +: WORD_W];
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  state_d = rd_stb ? BUS_RDATA : BUS_IDLE;
            BUS_RDATA: state_d = rd_stb ? BUS_RDATA : BUS_IDLE;
        endcase
    end

    // outputs
    assign bus_rvalid = (state_q == BUS_RDATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_stb) begin
            bus_rdata <= rd_mux;
        end else begin
            bus_rdata <= '0;
        end
    end

    AST_RVALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> bus_rvalid);  // R2
    AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !bus_rvalid);  // R2
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !(|stat_hit)) |=> (bus_rdata == '0));  // R11

endmodule

// File: rtl/cmpl_flag_bank.sv
module cmpl_flag_bank
    import cfb_pkg::*;
#(
    parameter int NUM_CH   = 256,
    parameter int CH_COUNT = 256,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [NUM_CH-1:0] xfer_done,
    input  logic [NUM_CH-1:0] xfer_irq_en,
    input  logic [NUM_CH-1:0] chain_irq,
    input  logic              standby_req,
    output logic [NUM_CH-1:0] irq_out
);

    localparam int NUM_WORDS = NUM_CH / WORD_W;

    logic [NUM_CH-1:0]    set_vec;
    logic [NUM_CH-1:0]    flags;
    logic [NUM_WORDS-1:0] clr_we;
    logic [WORD_W-1:0]    clr_bits;
    logic                 stat_wr;

    assign set_vec = (xfer_done & xfer_irq_en) | chain_irq;

    cfb_bus_port #(
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W),
        .STAT_BASE (ADDR_W'(8'h30)),
        .CLR_BASE  (ADDR_W'(8'h50))
    ) i_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .flags      (flags),
        .clr_we     (clr_we),
        .clr_bits   (clr_bits),
        .stat_wr    (stat_wr),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        cfb_flag_word #(
            .WORD_W   (WORD_W),
            .WORD_IDX (w),
            .CH_COUNT (CH_COUNT)
        ) i_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_in   (set_vec[w*WORD_W +: WORD_W]),
            .clr_we   (clr_we[w]),
            .clr_bits (clr_bits),
            .standby  (standby_req),
            .flags    (flags[w*WORD_W +: WORD_W])
        );
    end

    assign irq_out = flags;

    AST_STATUS_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !(|set_vec) && !standby_req) |=> $stable(flags));  // R5
    AST_ONE_CLEAR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_we));  // R6

endmodule

// File: tb/test_cmpl_flag_bank.sv
`timescale 1ns/1ps
module test_cmpl_flag_bank;

    localparam int NCH = 256;
    localparam int CHC = 128;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_sel = 1'b0;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           bus_rvalid;
    logic [NCH-1:0] xfer_done = '0;
    logic [NCH-1:0] xfer_irq_en = '0;
    logic [NCH-1:0] chain_irq = '0;
    logic           standby_req = 1'b0;
    logic [NCH-1:0] irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cmpl_flag_bank #(.NUM_CH(NCH), .CH_COUNT(CHC), .ADDR_W(8)) i_cmpl_flag_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .xfer_done(xfer_done), .xfer_irq_en(xfer_irq_en),
        .chain_irq(chain_irq), .standby_req(standby_req), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        chk("R2 rvalid", {31'd0, bus_rvalid}, 32'd1);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(input int ch);
        return (ch < CHC) ? (32'h1 << (ch % 32)) : 32'h0;
    endfunction

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'd0, |irq_out}, 32'd0);
        chk("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
        chk("R1 rdata", bus_rdata, 32'd0);
        for (int w = 0; w < 8; w++) begin
            rd(8'h30 + 8'(4 * w), d);
            chk("R1 word", d, 32'd0);
        end
        @(negedge clk);
        chk("R2 rvalid idle", {31'd0, bus_rvalid}, 32'd0);

        // sweep every channel position
        for (int ch = 0; ch < NCH; ch++) begin
            logic [7:0] sa;
            logic [7:0] ca;
            sa = 8'h30 + 8'(4 * (ch / 32));
            ca = 8'h50 + 8'(4 * (ch / 32));
            if (ch % 3 == 2) begin
                xfer_done[ch] = 1'b1;
                @(negedge clk);
                xfer_done[ch] = 1'b0;
                chk("R3 done without enable", {31'd0, irq_out[ch]}, 32'd0);
            end
            if (ch % 3 == 1) begin
                chain_irq[ch] = 1'b1;
            end else begin
                xfer_done[ch] = 1'b1;
                xfer_irq_en[ch] = 1'b1;
            end
            @(negedge clk);
            chain_irq = '0; xfer_done = '0; xfer_irq_en = '0;
            chk((ch % 3 == 1) ? "R4 R9 R10 irq" : "R3 R9 R10 irq",
                {31'd0, irq_out[ch]}, {31'd0, exp_word(ch) != 0});
            rd(sa, d);
            chk((ch % 3 == 1) ? "R4 R2 R10 word" : "R3 R2 R10 word", d, exp_word(ch));
            wr(sa, 32'hFFFF_FFFF);
            rd(sa, d);
            chk("R5 status write ignored", d, exp_word(ch));
            wr(ca, ~(32'h1 << (ch % 32)));
            rd(sa, d);
            chk("R6 zero bit keeps", d, exp_word(ch));
            wr(ca, 32'h1 << (ch % 32));
            rd(sa, d);
            chk("R6 one bit clears", d, 32'd0);
            chk("R9 irq cleared", {31'd0, irq_out[ch]}, 32'd0);
        end

        // R8 set wins over clear
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h50; bus_wdata = 32'h20;
        chain_irq[5] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; chain_irq = '0;
        rd(8'h30, d);
        chk("R8 set beats clear", d, 32'h20);
        wr(8'h50, 32'h20);

        // R7 standby clears all; R10 upper words stay zero
        chain_irq = '1;
        @(negedge clk);
        chain_irq = '0;
        for (int w = 0; w < 8; w++) begin
            rd(8'h30 + 8'(4 * w), d);
            chk("R10 full set", d, (w < CHC / 32) ? 32'hFFFF_FFFF : 32'h0);
        end
        // R11 clear words and unmapped offsets read zero
        rd(8'h50, d);  chk("R11 clear word", d, 32'd0);
        rd(8'h6C, d);  chk("R11 clear word", d, 32'd0);
        rd(8'h00, d);  chk("R11 unmapped", d, 32'd0);
        rd(8'h2C, d);  chk("R11 unmapped", d, 32'd0);
        rd(8'hFC, d);  chk("R11 unmapped", d, 32'd0);
        standby_req = 1'b1;
        chain_irq[7] = 1'b1;
        @(negedge clk);
        standby_req = 1'b0; chain_irq = '0;
        chk("R8 set beats standby", irq_out[31:0], 32'h80);
        chk("R7 standby clears", {31'd0, |irq_out[NCH-1:32]}, 32'd0);
        rd(8'h30, d);
        chk("R7 R8 word", d, 32'h80);
        standby_req = 1'b1;
        @(negedge clk);
        standby_req = 1'b0;
        chk("R7 standby all clear", {31'd0, |irq_out}, 32'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule